// File: doc/BRIEF.md
# CPU Load-Level Clock Selector

This block holds the CPU clock settings for four performance load levels and presents the source select, divider and alternate-clock flag of the active level to the clock generator. Each load level is described by a 16-bit slot. Two slots are packed into each of two 32-bit configuration words. A mode register turns dynamic operation on or off. A load register names the level currently in force. While dynamic operation is off, a separate static source/divider word drives the outputs.

Software writes and reads the registers through a simple single-cycle port. A source-change strobe sets one source select into all four level slots, but only while dynamic operation is off. A lookup strobe asks which level carries a given divider. One cycle later the block returns the lowest-numbered level whose divider matches, or it reports that no level matches.

Top module: `dvfs_level_sel`

## Requirements
- R1: After reset every register reads zero, dynamic operation is off, `src_o`, `div_o` and `alt_o` are zero, and `resp_valid_o` is low.
- R2: The register map has these addresses: 0 holds levels 0/1, 1 holds levels 2/3, 2 is mode (only bit 31 is kept; it is the dynamic enable), 3 is load (only bits 1:0 are kept), and 4 is static (divider in bits 2:0, source in bits 5:4). Bits that are not kept read as zero. A write becomes visible on the cycle after it is accepted.
- R3: Within a word, the even level (0 or 2) occupies bits 31:16 and the odd level (1 or 3) occupies bits 15:0. Within a slot, the divider sits at bits 15:13, the alternate flag at bit 11, and the source at bits 10:9.
- R4: With dynamic operation on, `src_o`, `div_o` and `alt_o` come from the slot of the level held in the load register.
- R5: With dynamic operation off, `src_o` and `div_o` come from the static word and `alt_o` is zero.
- R6: A `set_src_i` pulse while dynamic operation is off writes `src_i` into the source field of all four slots. It leaves every other slot bit and the static word unchanged. If a register write arrives in the same cycle, the pulse takes priority over the written source fields.
- R7: A `set_src_i` pulse while dynamic operation is on changes nothing.
- R8: A `req_i` pulse causes `resp_valid_o` to be high one cycle later. If dynamic operation is on and some level's divider equals `req_div_i`, `match_o` is 1 and `match_lvl_o` gives the lowest such level.
- R9: If no level matches, or dynamic operation is off, the response has `match_o` = 0 and `match_lvl_o` = 0.
- R10: `resp_valid_o` is high only in the cycle that follows a `req_i` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write enable |
| addr_i | input | 3 | Register address for writes and reads |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| set_src_i | input | 1 | Set the source of all level slots |
| src_i | input | 2 | Source value for `set_src_i` |
| req_i | input | 1 | Divider lookup strobe |
| req_div_i | input | 3 | Divider to look up |
| resp_valid_o | output | 1 | Lookup response valid |
| match_o | output | 1 | Lookup found a level |
| match_lvl_o | output | 2 | Lowest matching level |
| src_o | output | 2 | Effective clock source select |
| div_o | output | 3 | Effective clock divider |
| alt_o | output | 1 | Effective alternate-clock flag |

## Verification
The properties assume that reset has been released before any strobe is given. They also assume that `set_src_i` is not combined with a register write when its no-change behaviour is checked. The lookup properties compare against the configuration words as they stood in the request cycle, so the configuration may change on the following cycle without any false alarm. The stimulus draws random words, modes, loads and divider requests from a fixed seed. It issues lookups and source changes as isolated single-cycle pulses, and it adds directed cases for duplicate dividers, absent dividers and lookups made in static mode.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
  localparam int NUM_LVL  = 4;
  localparam int LVL_W    = $clog2(NUM_LVL);
  localparam int DIV_W    = 3;
  localparam int SRC_W    = 2;
  localparam int WORD_W   = 32;
  localparam int SLOT_W   = WORD_W / 2;
  localparam int NUM_WORD = NUM_LVL / 2;
  localparam int DIV_OFF  = 13;
  localparam int ALT_OFF  = 11;
  localparam int SRC_OFF  = 9;
  localparam int MODE_BIT = 31;
  localparam int ADDR_W   = 3;
  localparam int SDIV_OFF = 0;
  localparam int SSRC_OFF = 4;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_LVL01  = 3'd0,
    ADDR_LVL23  = 3'd1,
    ADDR_MODE   = 3'd2,
    ADDR_LOAD   = 3'd3,
    ADDR_STATIC = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             alt;
    logic [SRC_W-1:0] src;
  } lvl_cfg_t;

  function automatic lvl_cfg_t slot_decode(logic [NUM_WORD-1:0][WORD_W-1:0] words,
                                           logic [LVL_W-1:0] lvl);
    logic [WORD_W-1:0] w;
    logic [SLOT_W-1:0] s;
    lvl_cfg_t c;
    w = words[lvl[LVL_W-1:1]];
    // even level lives in the upper half
    s = lvl[0] ? w[SLOT_W-1:0] : w[WORD_W-1:SLOT_W];
    c.div = s[DIV_OFF +: DIV_W];
    c.alt = s[ALT_OFF];
    c.src = s[SRC_OFF +: SRC_W];
    return c;
  endfunction
endpackage

// File: rtl/dvfs_regs.sv
module dvfs_regs
  import dvfs_pkg::*;
(
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [WORD_W-1:0]                wdata_i,
  input  logic                             set_src_i,
  input  logic [SRC_W-1:0]                 src_i,
  output logic [NUM_WORD-1:0][WORD_W-1:0]  words_o,
  output logic                             dyn_en_o,
  output logic [LVL_W-1:0]                 load_o,
  output logic [DIV_W-1:0]                 sdiv_o,
  output logic [SRC_W-1:0]                 ssrc_o
);
  logic [NUM_WORD-1:0][WORD_W-1:0] words_q, words_d;
  logic             dyn_q, dyn_d;
  logic [LVL_W-1:0] load_q, load_d;
  logic [DIV_W-1:0] sdiv_q, sdiv_d;
  logic [SRC_W-1:0] ssrc_q, ssrc_d;

  always_comb begin
    words_d = words_q;
    dyn_d   = dyn_q;
    load_d  = load_q;
    sdiv_d  = sdiv_q;
    ssrc_d  = ssrc_q;
    if (wr_en_i) begin
      case (addr_i)
        ADDR_LVL01:  words_d[0] = wdata_i;
        ADDR_LVL23:  words_d[1] = wdata_i;
        ADDR_MODE:   dyn_d      = wdata_i[MODE_BIT];
        ADDR_LOAD:   load_d     = wdata_i[LVL_W-1:0];
        ADDR_STATIC: begin
          sdiv_d = wdata_i[SDIV_OFF +: DIV_W];
          ssrc_d = wdata_i[SSRC_OFF +: SRC_W];
        end
        default: ;
      endcase
    end
    // source broadcast only while per-level mode is off; overrides a same-cycle write
    if (set_src_i && !dyn_q) begin
      for (int w = 0; w < NUM_WORD; w++) begin
        for (int h = 0; h < 2; h++) begin
          words_d[w][h*SLOT_W + SRC_OFF +: SRC_W] = src_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      words_q <= '0;
      dyn_q   <= 1'b0;
      load_q  <= '0;
      sdiv_q  <= '0;
      ssrc_q  <= '0;
    end else begin
      words_q <= words_d;
      dyn_q   <= dyn_d;
      load_q  <= load_d;
      sdiv_q  <= sdiv_d;
      ssrc_q  <= ssrc_d;
    end
  end

  assign words_o  = words_q;
  assign dyn_en_o = dyn_q;
  assign load_o   = load_q;
  assign sdiv_o   = sdiv_q;
  assign ssrc_o   = ssrc_q;
endmodule

// File: rtl/dvfs_slot_decode.sv
module dvfs_slot_decode
  import dvfs_pkg::*;
(
  input  logic [NUM_WORD-1:0][WORD_W-1:0] words_i,
  output lvl_cfg_t [NUM_LVL-1:0]          cfg_o
);
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    assign cfg_o[l] = slot_decode(words_i, LVL_W'(l));
  end
endmodule

// File: rtl/dvfs_match.sv
module dvfs_match
  import dvfs_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic [DIV_W-1:0]       req_div_i,
  input  logic                   dyn_en_i,
  input  lvl_cfg_t [NUM_LVL-1:0] cfg_i,
  output logic                   valid_o,
  output logic                   hit_o,
  output logic [LVL_W-1:0]       lvl_o
);
  logic             hit_d;
  logic [LVL_W-1:0] lvl_d;

  // descending scan so the lowest matching level wins
  always_comb begin
    hit_d = 1'b0;
    lvl_d = '0;
    for (int l = NUM_LVL - 1; l >= 0; l--) begin
      if (cfg_i[l].div == req_div_i) begin
        hit_d = 1'b1;
        lvl_d = LVL_W'(l);
      end
    end
    if (!dyn_en_i) begin
      hit_d = 1'b0;
      lvl_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      hit_o   <= 1'b0;
      lvl_o   <= '0;
    end else begin
      valid_o <= req_i;
      hit_o   <= req_i & hit_d;
      lvl_o   <= req_i ? lvl_d : '0;
    end
  end
endmodule

// File: rtl/dvfs_level_sel.sv
module dvfs_level_sel
  import dvfs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        set_src_i,
  input  logic [1:0]  src_i,
  input  logic        req_i,
  input  logic [2:0]  req_div_i,
  output logic        resp_valid_o,
  output logic        match_o,
  output logic [1:0]  match_lvl_o,
  output logic [1:0]  src_o,
  output logic [2:0]  div_o,
  output logic        alt_o
);
  logic [NUM_WORD-1:0][WORD_W-1:0] lvl_words;
  logic                   dyn_en;
  logic [LVL_W-1:0]       load_lvl;
  logic [DIV_W-1:0]       sdiv;
  logic [SRC_W-1:0]       ssrc;
  lvl_cfg_t [NUM_LVL-1:0] cfg;

  dvfs_regs i_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .set_src_i, .src_i,
    .words_o(lvl_words), .dyn_en_o(dyn_en), .load_o(load_lvl),
    .sdiv_o(sdiv), .ssrc_o(ssrc)
  );

  dvfs_slot_decode i_dec (.words_i(lvl_words), .cfg_o(cfg));

  dvfs_match i_match (
    .clk_i, .rst_ni, .req_i, .req_div_i, .dyn_en_i(dyn_en), .cfg_i(cfg),
    .valid_o(resp_valid_o), .hit_o(match_o), .lvl_o(match_lvl_o)
  );

  always_comb begin
    if (dyn_en) begin
      src_o = cfg[load_lvl].src;
      div_o = cfg[load_lvl].div;
      alt_o = cfg[load_lvl].alt;
    end else begin
      src_o = ssrc;
      div_o = sdiv;
      alt_o = 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_LVL01:  rdata_o = lvl_words[0];
      ADDR_LVL23:  rdata_o = lvl_words[1];
      ADDR_MODE:   rdata_o[MODE_BIT] = dyn_en;
      ADDR_LOAD:   rdata_o[LVL_W-1:0] = load_lvl;
      ADDR_STATIC: begin
        rdata_o[SDIV_OFF +: DIV_W] = sdiv;
        rdata_o[SSRC_OFF +: SRC_W] = ssrc;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dvfs_level_sel_chk.sv
module dvfs_level_sel_chk
  import dvfs_pkg::*;
(
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            wr_en_i,
  input logic                            set_src_i,
  input logic [SRC_W-1:0]                src_i,
  input logic                            req_i,
  input logic [DIV_W-1:0]                req_div_i,
  input logic                            resp_valid_o,
  input logic                            match_o,
  input logic [LVL_W-1:0]                match_lvl_o,
  input logic [NUM_WORD-1:0][WORD_W-1:0] lvl_words,
  input logic                            dyn_en
);
  a_r10_resp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> resp_valid_o);
  a_r10_no_stray_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !resp_valid_o);
  a_r8_hit_div_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (!match_o || slot_decode($past(lvl_words), match_lvl_o).div == $past(req_div_i)));
  a_r8_hit_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (!match_o || match_lvl_o == 2'd0
               || slot_decode($past(lvl_words), 2'd0).div != $past(req_div_i)));
  a_r9_static_fails: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !dyn_en) |=> !match_o);
  a_r6_src_broadcast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_src_i && !dyn_en) |=> (slot_decode(lvl_words, 2'd0).src == $past(src_i)
                                && slot_decode(lvl_words, 2'd3).src == $past(src_i)));
  a_r7_src_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_src_i && dyn_en && !wr_en_i) |=> $stable(lvl_words));
endmodule

bind dvfs_level_sel dvfs_level_sel_chk i_chk (
  .clk_i, .rst_ni, .wr_en_i, .set_src_i, .src_i, .req_i, .req_div_i,
  .resp_valid_o, .match_o, .match_lvl_o, .lvl_words, .dyn_en
);

// File: tb/test_dvfs_level_sel.sv
module test_dvfs_level_sel;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        set_src_i = 1'b0;
  logic [1:0]  src_i = '0;
  logic        req_i = 1'b0;
  logic [2:0]  req_div_i = '0;
  logic        resp_valid_o, match_o, alt_o;
  logic [1:0]  match_lvl_o, src_o;
  logic [2:0]  div_o;

  int total = 0;
  int bad = 0;

  logic [31:0] m_w [2];
  logic        m_dyn;
  logic [1:0]  m_load;
  logic [2:0]  m_sdiv;
  logic [1:0]  m_ssrc;

  always #4 clk_i = ~clk_i;

  dvfs_level_sel i_dvfs_level_sel (.*);

  function automatic logic [15:0] m_slot(int lvl);
    return (lvl % 2 == 0) ? m_w[lvl/2][31:16] : m_w[lvl/2][15:0];
  endfunction

  function automatic logic [5:0] m_eff();
    logic [15:0] s;
    if (!m_dyn) return {m_sdiv, 1'b0, m_ssrc};
    s = m_slot(int'(m_load));
    return {s[15:13], s[11], s[10:9]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    case (a)
      3'd0: m_w[0] = d;
      3'd1: m_w[1] = d;
      3'd2: m_dyn = d[31];
      3'd3: m_load = d[1:0];
      3'd4: begin m_sdiv = d[2:0]; m_ssrc = d[5:4]; end
      default: ;
    endcase
  endtask

  task automatic rd_chk(string req, logic [2:0] a, logic [31:0] exp);
    addr_i = a;
    #1;
    chk(req, rdata_o, exp);
  endtask

  task automatic eff_chk(string req);
    chk(req, {26'd0, div_o, alt_o, src_o}, {26'd0, m_eff()});
  endtask

  task automatic set_src(logic [1:0] s);
    @(negedge clk_i);
    set_src_i = 1'b1; src_i = s;
    @(negedge clk_i);
    set_src_i = 1'b0;
    if (!m_dyn) begin
      for (int w = 0; w < 2; w++) begin
        m_w[w][10:9] = s;
        m_w[w][26:25] = s;
      end
    end
  endtask

  task automatic lookup(logic [2:0] d);
    logic       e_hit = 1'b0;
    logic [1:0] e_lvl = 2'd0;
    for (int l = 0; l < 4; l++) begin
      if (!e_hit && m_dyn && m_slot(l) >> 13 == d) begin
        e_hit = 1'b1; e_lvl = 2'(l);
      end
    end
    @(negedge clk_i);
    req_i = 1'b1; req_div_i = d;
    @(negedge clk_i);
    req_i = 1'b0;
    chk("R10 resp valid", {31'd0, resp_valid_o}, 32'd1);
    chk(m_dyn ? "R8 match" : "R9 static no match", {31'd0, match_o}, {31'd0, e_hit});
    chk("R8 level", {30'd0, match_lvl_o}, {30'd0, e_lvl});
    @(negedge clk_i);
    chk("R10 resp one cycle", {31'd0, resp_valid_o}, 32'd0);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_w[0] = '0; m_w[1] = '0; m_dyn = 0; m_load = 0; m_sdiv = 0; m_ssrc = 0;
    #20 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    for (int a = 0; a < 5; a++) rd_chk("R1 reset reg", 3'(a), 32'd0);
    chk("R1 reset outputs", {26'd0, div_o, alt_o, src_o}, 32'd0);
    chk("R1 reset resp", {31'd0, resp_valid_o}, 32'd0);

    // R2 kept bits
    wr(3'd2, 32'hFFFF_FFFF); rd_chk("R2 mode bits", 3'd2, 32'h8000_0000);
    wr(3'd3, 32'hFFFF_FFFF); rd_chk("R2 load bits", 3'd3, 32'h0000_0003);
    wr(3'd4, 32'hFFFF_FFFF); rd_chk("R2 static bits", 3'd4, 32'h0000_0037);

    // R3 layout: lvl0 div5 alt1 src2, lvl1 div3 alt0 src1
    wr(3'd0, 32'hAC00_6200);
    wr(3'd3, 32'd0);
    chk("R3 even slot upper", {26'd0, div_o, alt_o, src_o}, {26'd0, 3'd5, 1'b1, 2'd2});
    wr(3'd3, 32'd1);
    chk("R3 odd slot lower", {26'd0, div_o, alt_o, src_o}, {26'd0, 3'd3, 1'b0, 2'd1});

    // R5 static mode
    wr(3'd2, 32'd0);
    wr(3'd4, 32'h0000_0026);
    chk("R5 static out", {26'd0, div_o, alt_o, src_o}, {26'd0, 3'd6, 1'b0, 2'd2});

    // R6 broadcast in static mode, static word untouched
    wr(3'd1, 32'h1234_5678);
    set_src(2'd3);
    rd_chk("R6 word0", 3'd0, m_w[0]);
    rd_chk("R6 word1", 3'd1, m_w[1]);
    chk("R6 static unchanged", {26'd0, div_o, alt_o, src_o}, {26'd0, 3'd6, 1'b0, 2'd2});

    // R7 ignored in dynamic mode
    wr(3'd2, 32'h8000_0000);
    set_src(2'd0);
    rd_chk("R7 word0 kept", 3'd0, m_w[0]);
    rd_chk("R7 word1 kept", 3'd1, m_w[1]);

    // R8/R9 directed: duplicate dividers, absent divider, static lookup
    wr(3'd0, {3'd2, 13'd0, 3'd4, 13'd0});
    wr(3'd1, {3'd4, 13'd0, 3'd2, 13'd0});
    lookup(3'd4);
    lookup(3'd2);
    lookup(3'd7);
    wr(3'd2, 32'd0);
    lookup(3'd4);

    // random mix, R4 and R5 outputs plus lookups
    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 5);
      case (op)
        0: wr(1'($urandom_range(0, 1)), $urandom());
        1: wr(3'd2, {$urandom_range(0, 1) == 1, 31'($urandom())});
        2: wr(3'd3, $urandom());
        3: wr(3'd4, $urandom());
        4: set_src(2'($urandom_range(0, 3)));
        default: lookup(3'($urandom_range(0, 7)));
      endcase
      eff_chk(m_dyn ? "R4 dynamic out" : "R5 static out");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule